// File: doc/BRIEF.md
# Sinc Decimation Filter with PWM-Locked Capture

This block turns a one-bit sigma-delta bitstream into decimated current samples. Each modulator bit arrives with a one-cycle qualifier, `mod_vld`, in the system clock domain. A chain of integrators runs at the bit rate. Once per decimation interval, a chain of differentiators (comb stages) produces one result. The filter order (one, two or three stages) and the oversampling ratio are chosen at run time.

Results can be delivered in two ways:
- **Continuous mode** hands every settled result to the output with a strobe and an interrupt.
- **Trigger mode** ignores the decimation rhythm. It publishes the most recent settled result at one or two programmable cycle offsets after each PWM period start. With two offsets per period, the interrupt is raised once, on the later capture.

A change of order or ratio restarts the filter. Output is withheld until a full filter window of new data has been seen.

Top module: `sinc_decim`

## Requirements
- R1: While reset is held, `smp_data` is zero and `smp_vld` and `smp_irq` are low.
- R2: `ord_sel` = 1 selects a single stage. Each result then equals the number of ones among the last N bits, where N is the effective oversampling ratio. A result is produced after every N-th accepted bit.
- R3: `ord_sel` = 2 selects two stages, and `ord_sel` = 0 or 3 selects three stages. A result equals the last bits convolved with a length-N box repeated K times (K = order). An all-ones input therefore reads exactly N^K, so each extra stage multiplies the full scale by N.
- R4: The effective ratio N is `osr_sel` clamped into the range 8 to 256. A value below 8 acts as 8, and a value above 256 acts as 256.
- R5: In continuous mode (`trig_mode` = 0), each settled result appears on `smp_data` with `smp_vld` and `smp_irq` high for one cycle. This happens in the cycle after the clock edge that accepted the bit completing the interval.
- R6: After a restart, the first K−1 results are withheld. The first strobe follows K·N accepted bits.
- R7: A change in effective order or ratio is detected at a clock edge. That edge clears the filter, discards any bit offered in that cycle, and produces no strobe.
- R8: In trigger mode, let `pwm_sync` be sampled high at edge E. If a settled result exists, it is published with `smp_vld` high after edge E + `trig_a` + 1. The result published is the one held before that edge. Decimation results themselves produce no strobe.
- R9: With `dbl_en` = 1, a second capture occurs at offset `trig_b` in the same period. `smp_irq` is high only on the `trig_b` capture, while both captures raise `smp_vld`. With `dbl_en` = 0, `smp_irq` accompanies the `trig_a` capture.
- R10: A trigger that occurs before any settled result exists after a restart produces no strobe.
- R11: A published sample never exceeds N^K for the configuration that produced it.
- R12: `smp_irq` is never high without `smp_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_bit | input | 1 | Modulator data bit |
| mod_vld | input | 1 | Qualifies `mod_bit` for one cycle per modulator clock |
| ord_sel | input | 2 | Filter order: 1, 2, or 0/3 for three stages |
| osr_sel | input | 9 | Oversampling ratio request (clamped to 8..256) |
| trig_mode | input | 1 | 0 continuous, 1 PWM-locked capture |
| dbl_en | input | 1 | Enables the second capture point per period |
| pwm_sync | input | 1 | One-cycle PWM period start |
| trig_a | input | 16 | First capture offset in cycles after period start |
| trig_b | input | 16 | Second capture offset in cycles after period start |
| smp_data | output | 25 | Filtered sample, unsigned count 0..N^K |
| smp_vld | output | 1 | Sample strobe |
| smp_irq | output | 1 | Interrupt pulse |

## Verification
The filter is driven with a pseudo-random bit density, alternating bits and long runs of ones and zeros. Random and alternating data separate the convolution shapes of the three orders. Runs of ones pin the full-scale value, and with it the per-stage scaling and the ratio clamp. Configuration changes land both between bits and on the same cycle as a bit, to expose whether the offered bit is dropped and whether the settling count restarts. PWM periods are run with single and double capture, and once before any settled result exists, so that capture timing, interrupt placement and the empty-filter case are each seen on their own.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

   typedef enum logic {
      CAP_CONT = 1'b0,
      CAP_TRIG = 1'b1
   } cap_mode_e;

   // Map the order request onto 1..max_stg; zero or too large means full order.
   function automatic logic [1:0] ord_norm(input logic [1:0] sel, input int max_stg);
      if (sel == 2'd0 || int'(sel) > max_stg) return 2'(max_stg);
      return sel;
   endfunction

endpackage

// File: rtl/sdf_integ.sv
module sdf_integ #(
   parameter int ACC_W = 25,
   parameter int NSTG  = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        en,
   input  logic                        bit_in,
   output logic [NSTG-1:0][ACC_W-1:0]  acc_nxt
);

   for (genvar s = 0; s < NSTG; s++) begin : g_stg
      logic [ACC_W-1:0] acc_q;
      logic [ACC_W-1:0] nxt;

      if (s == 0) begin : g_first
         assign nxt = acc_q + {{(ACC_W-1){1'b0}}, bit_in};
      end else begin : g_next
         assign nxt = acc_q + g_stg[s-1].nxt;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   acc_q <= '0;
         else if (clr) acc_q <= '0;
         else if (en)  acc_q <= nxt;
      end

      assign acc_nxt[s] = nxt;
   end

endmodule

// File: rtl/sdf_comb.sv
module sdf_comb #(
   parameter int ACC_W = 25,
   parameter int NSTG  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              dec,
   input  logic [1:0]        order,
   input  logic [ACC_W-1:0]  src,
   output logic [ACC_W-1:0]  y
);

   for (genvar s = 0; s < NSTG; s++) begin : g_stg
      logic [ACC_W-1:0] din;
      logic [ACC_W-1:0] dly_q;
      logic [ACC_W-1:0] dout;

      if (s == 0) begin : g_first
         assign din = src;
      end else begin : g_next
         assign din = g_stg[s-1].dout;
      end

      assign dout = (int'(order) > s) ? din - dly_q : din;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   dly_q <= '0;
         else if (clr) dly_q <= '0;
         else if (dec) dly_q <= din;
      end
   end

   assign y = g_stg[NSTG-1].dout;

endmodule

// File: rtl/sdf_trig.sv
module sdf_trig #(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync,
   input  logic              dbl,
   input  logic [CNT_W-1:0]  ofs_a,
   input  logic [CNT_W-1:0]  ofs_b,
   output logic              fire,
   output logic              last
);

   logic [CNT_W-1:0] cnt_q;
   logic             act_q;
   logic             hit_a;
   logic             hit_b;

   assign hit_a = act_q && (cnt_q == ofs_a);
   assign hit_b = act_q && dbl && (cnt_q == ofs_b);
   assign fire  = hit_a || hit_b;
   assign last  = dbl ? hit_b : hit_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (sync) begin
         cnt_q <= '0;
         act_q <= 1'b1;
      end else if (act_q) begin
         if (&cnt_q) act_q <= 1'b0;
         else        cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim #(
   parameter int OSR_MIN = 8,
   parameter int OSR_MAX = 256,
   parameter int NSTG    = 3,
   parameter int CNT_W   = 16,
   localparam int OSR_W  = $clog2(OSR_MAX) + 1,
   localparam int ACC_W  = NSTG * $clog2(OSR_MAX) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_bit,
   input  logic              mod_vld,
   input  logic [1:0]        ord_sel,
   input  logic [OSR_W-1:0]  osr_sel,
   input  logic              trig_mode,
   input  logic              dbl_en,
   input  logic              pwm_sync,
   input  logic [CNT_W-1:0]  trig_a,
   input  logic [CNT_W-1:0]  trig_b,
   output logic [ACC_W-1:0]  smp_data,
   output logic              smp_vld,
   output logic              smp_irq
);
   import sdf_pkg::*;

   initial begin
      assert (NSTG >= 1 && NSTG <= 3);
      assert (OSR_MIN >= 2 && OSR_MIN <= OSR_MAX);
      assert (CNT_W >= 2);
   end

   logic [OSR_W-1:0]  osr_c, osr_q, bit_cnt_q;
   logic [1:0]        ord_c, ord_q, set_q;
   logic              cfg_chg, acc_en, dec, dec_ok, fire, last, fire_ok, has_q;
   logic [NSTG-1:0][ACC_W-1:0] acc_nxt;
   logic [ACC_W-1:0]  src, y, res_q;
   cap_mode_e         mode;

   assign mode = cap_mode_e'(trig_mode);

   always_comb begin
      if (osr_sel < OSR_W'(OSR_MIN))      osr_c = OSR_W'(OSR_MIN);
      else if (osr_sel > OSR_W'(OSR_MAX)) osr_c = OSR_W'(OSR_MAX);
      else                                osr_c = osr_sel;
   end

   assign ord_c   = ord_norm(ord_sel, NSTG);
   assign cfg_chg = (osr_c != osr_q) || (ord_c != ord_q);
   assign acc_en  = mod_vld && !cfg_chg;
   assign dec     = acc_en && (bit_cnt_q == osr_q - 1'b1);
   assign dec_ok  = dec && (({1'b0, set_q} + 3'd1) >= {1'b0, ord_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osr_q     <= OSR_W'(OSR_MAX);
         ord_q     <= 2'(NSTG);
         bit_cnt_q <= '0;
         set_q     <= '0;
      end else if (cfg_chg) begin
         osr_q     <= osr_c;
         ord_q     <= ord_c;
         bit_cnt_q <= '0;
         set_q     <= '0;
      end else if (acc_en) begin
         bit_cnt_q <= dec ? '0 : bit_cnt_q + 1'b1;
         if (dec && set_q != 2'd3) set_q <= set_q + 2'd1;
      end
   end

   sdf_integ #(.ACC_W(ACC_W), .NSTG(NSTG)) u_integ (
      .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .en(acc_en),
      .bit_in(mod_bit), .acc_nxt(acc_nxt)
   );

   always_comb begin
      src = '0;
      for (int k = 0; k < NSTG; k++)
         if (int'(ord_q) == k + 1) src = acc_nxt[k];
   end

   sdf_comb #(.ACC_W(ACC_W), .NSTG(NSTG)) u_comb (
      .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .dec(dec),
      .order(ord_q), .src(src), .y(y)
   );

   sdf_trig #(.CNT_W(CNT_W)) u_trig (
      .clk(clk), .rst_n(rst_n), .sync(pwm_sync), .dbl(dbl_en),
      .ofs_a(trig_a), .ofs_b(trig_b), .fire(fire), .last(last)
   );

   assign fire_ok = (mode == CAP_TRIG) && fire && has_q && !cfg_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q    <= '0;
         has_q    <= 1'b0;
         smp_data <= '0;
         smp_vld  <= 1'b0;
         smp_irq  <= 1'b0;
      end else begin
         smp_vld <= 1'b0;
         smp_irq <= 1'b0;
         if (cfg_chg) begin
            has_q <= 1'b0;
         end else begin
            if (fire_ok) begin
               smp_data <= res_q;
               smp_vld  <= 1'b1;
               smp_irq  <= last;
            end
            if (dec_ok) begin
               res_q <= y;
               has_q <= 1'b1;
               if (mode == CAP_CONT) begin
                  smp_data <= y;
                  smp_vld  <= 1'b1;
                  smp_irq  <= 1'b1;
               end
            end
         end
      end
   end

   // Full-scale bound of the active configuration, used only by the checks.
   logic [ACC_W-1:0] fs_lim;
   always_comb begin
      fs_lim = {{(ACC_W-1){1'b0}}, 1'b1};
      for (int k = 0; k < NSTG; k++)
         if (k < int'(ord_q)) fs_lim = fs_lim * ACC_W'(osr_q);
   end

   // R11
   range_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |-> smp_data <= fs_lim);

   // R12
   irq_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_irq |-> smp_vld);

   // R7
   cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> !smp_vld);

   // R5
   cont_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !$past(trig_mode)) |-> $past(mod_vld));

   // R6
   settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !trig_mode && set_q == 2'd0 && ord_q != 2'd1) |=> !smp_vld);

endmodule

// File: tb/sinc_decim_bench.sv
`timescale 1ns/1ps
module sinc_decim_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_bit = 1'b0, mod_vld = 1'b0;
   logic [1:0]  ord_sel = 2'd1;
   logic [8:0]  osr_sel = 9'd8;
   logic        trig_mode = 1'b0, dbl_en = 1'b0, pwm_sync = 1'b0;
   logic [15:0] trig_a = 16'd0, trig_b = 16'd0;
   logic [24:0] smp_data;
   logic        smp_vld, smp_irq;

   always #2.5 clk = ~clk;

   sinc_decim u_sinc_decim (
      .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .mod_vld(mod_vld),
      .ord_sel(ord_sel), .osr_sel(osr_sel), .trig_mode(trig_mode),
      .dbl_en(dbl_en), .pwm_sync(pwm_sync), .trig_a(trig_a), .trig_b(trig_b),
      .smp_data(smp_data), .smp_vld(smp_vld), .smp_irq(smp_irq)
   );

   int n_cmp = 0, n_bad = 0;
   int n_vld = 0, n_irq = 0, last_seen = 0, cyc = 0;
   string tag = "R1";

   // ---------------- reference model ----------------
   int q_bits[$];
   int h[];
   int m_osr = 256, m_ord = 3, bcnt = 0, ndec = 0, has = 0, last_res = 0;
   int ph = 0, act = 0;
   int e_vld = 0, e_irq = 0, e_smp = 0;

   function automatic int eff_osr(int v);
      if (v < 8) return 8;
      if (v > 256) return 256;
      return v;
   endfunction

   function automatic int eff_ord(int v);
      return (v == 1 || v == 2) ? v : 3;
   endfunction

   task automatic build_h(int n, int k);
      int cur[];
      int nxt[];
      cur = new[1];
      cur[0] = 1;
      for (int s = 0; s < k; s++) begin
         nxt = new[cur.size() + n - 1];
         foreach (nxt[i]) nxt[i] = 0;
         foreach (cur[i]) for (int j = 0; j < n; j++) nxt[i+j] += cur[i];
         cur = nxt;
      end
      h = cur;
   endtask

   function automatic int conv();
      int y = 0;
      for (int j = 0; j < h.size(); j++)
         if (j < q_bits.size()) y += h[j] * q_bits[q_bits.size()-1-j];
      return y;
   endfunction

   initial build_h(256, 3);

   always @(posedge clk) begin
      if (!rst_n) begin
         m_osr = 256; m_ord = 3; bcnt = 0; ndec = 0; has = 0; last_res = 0;
         ph = 0; act = 0; e_vld = 0; e_irq = 0; e_smp = 0;
         q_bits.delete();
         build_h(256, 3);
      end else begin
         int f_a, f_b, chg, y;
         f_a = act && (ph == int'(trig_a));
         f_b = act && dbl_en && (ph == int'(trig_b));
         chg = (eff_osr(osr_sel) != m_osr) || (eff_ord(ord_sel) != m_ord);
         e_vld = 0; e_irq = 0;
         if (chg) begin
            m_osr = eff_osr(osr_sel); m_ord = eff_ord(ord_sel);
            bcnt = 0; ndec = 0; has = 0;
            q_bits.delete();
            build_h(m_osr, m_ord);
         end else begin
            if (trig_mode && (f_a || f_b) && has) begin
               e_vld = 1; e_smp = last_res;
               e_irq = dbl_en ? f_b : f_a;
            end
            if (mod_vld) begin
               q_bits.push_back(int'(mod_bit));
               if (q_bits.size() > 800) void'(q_bits.pop_front());
               bcnt++;
               if (bcnt == m_osr) begin
                  bcnt = 0; ndec++;
                  if (ndec >= m_ord) begin
                     y = conv(); last_res = y; has = 1;
                     if (!trig_mode) begin e_vld = 1; e_irq = 1; e_smp = y; end
                  end
               end
            end
         end
         if (pwm_sync) begin ph = 0; act = 1; end
         else if (act) begin
            if (ph == 65535) act = 0; else ph++;
         end
      end
   end

   // ---------------- cycle compare ----------------
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         n_cmp++;
         if (int'(smp_vld) != e_vld || int'(smp_irq) != e_irq ||
             (e_vld && int'(smp_data) != e_smp)) begin
            n_bad++;
            $display("FAIL %s cyc %0d: vld/irq/data act %0d/%0d/%0d exp %0d/%0d/%0d",
                     tag, cyc, smp_vld, smp_irq, smp_data, e_vld, e_irq, e_smp);
         end
         if (smp_vld) begin n_vld++; last_seen = int'(smp_data); end
         if (smp_irq) n_irq++;
      end
   end

   task automatic chk(int act_v, int exp_v, string req);
      n_cmp++;
      if (act_v != exp_v) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
      end
   endtask

   // ---------------- stimulus ----------------
   logic [15:0] lfsr = 16'hACE1;

   task automatic send_bit(logic b);
      @(negedge clk); mod_vld = 1'b1; mod_bit = b;
      @(negedge clk); mod_vld = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_rand(int n);
      for (int i = 0; i < n; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         send_bit(lfsr[0]);
      end
   endtask

   task automatic send_const(logic b, int n);
      for (int i = 0; i < n; i++) send_bit(b);
   endtask

   task automatic set_cfg(int o, int r);
      @(negedge clk); ord_sel = 2'(o); osr_sel = 9'(r);
      repeat (3) @(negedge clk);
      n_vld = 0; n_irq = 0;
   endtask

   task automatic syncs(int periods, int len);
      for (int p = 0; p < periods; p++) begin
         @(negedge clk); pwm_sync = 1'b1;
         @(negedge clk); pwm_sync = 1'b0;
         repeat (len - 2) @(negedge clk);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      wait (cyc > 150000);
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      tag = "R1";
      chk(int'(smp_data), 0, "R1 data");
      chk(int'(smp_vld), 0, "R1 vld");
      chk(int'(smp_irq), 0, "R1 irq");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      tag = "R2 R5 sinc1 random";
      set_cfg(1, 8);  send_rand(64);
      chk(n_vld, 8, "R5 strobes");
      chk(n_irq, 8, "R5 irqs");

      tag = "R3 sinc2 alternating";
      set_cfg(2, 16);
      for (int i = 0; i < 80; i++) send_bit(i[0]);
      tag = "R3 sinc3 random";
      set_cfg(3, 32); send_rand(160);

      tag = "R3 full scale";
      set_cfg(0, 256); send_const(1'b1, 1024);
      chk(last_seen, 16777216, "R3 sinc3 N=256 full scale");
      send_const(1'b0, 768);
      chk(last_seen, 0, "R3 all zeros");

      tag = "R4 clamp low";
      set_cfg(2, 4); send_const(1'b1, 40);
      chk(last_seen, 64, "R4 osr 4 acts as 8");
      tag = "R4 clamp high";
      set_cfg(1, 300); send_const(1'b1, 512);
      chk(last_seen, 256, "R4 osr 300 acts as 256");

      tag = "R6 settle";
      set_cfg(3, 8); send_rand(40);
      chk(n_vld, 3, "R6 first K-1 withheld");

      tag = "R7 change on bit";
      set_cfg(2, 8); send_rand(12);
      @(negedge clk); osr_sel = 9'd16; mod_vld = 1'b1; mod_bit = 1'b1;
      @(negedge clk); mod_vld = 1'b0;
      n_vld = 0;
      repeat (2) @(negedge clk);
      send_const(1'b1, 40);
      chk(n_vld, 1, "R7 restart count");
      chk(last_seen, 256, "R7 data after restart");

      tag = "R10 empty trigger";
      trig_mode = 1'b1; trig_a = 16'd50; dbl_en = 1'b0;
      set_cfg(3, 256);
      fork
         send_rand(100);
         syncs(2, 200);
      join
      chk(n_vld, 0, "R10 no strobe without result");

      tag = "R8 single trigger";
      set_cfg(1, 8); send_rand(40);
      n_vld = 0; n_irq = 0;
      fork
         send_rand(200);
         syncs(4, 200);
      join
      chk(n_vld, 4, "R8 one capture per period");
      chk(n_irq, 4, "R9 irq with single capture");

      tag = "R9 double trigger";
      dbl_en = 1'b1; trig_a = 16'd40; trig_b = 16'd140;
      repeat (3) @(negedge clk);
      n_vld = 0; n_irq = 0;
      fork
         send_rand(200);
         syncs(4, 200);
      join
      chk(n_vld, 8, "R9 two captures per period");
      chk(n_irq, 4, "R9 irq only on second capture");

      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule